// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block prepares an asynchronous DRAM for use after reset and keeps its contents alive from then on. It first holds every strobe inactive for a start-up pause. It then runs a burst of eight wake-up refresh cycles without asking for the bus. Only after the last of these does it raise its ready flag. From that point a free-running interval timer raises a refresh request often enough that every row is refreshed once within the refresh period.

The access controller answers a request with a grant. When a grant is accepted, the sequencer drives one CAS-before-RAS refresh cycle on its strobe outputs, and the controller routes those strobes to the DRAM pins. Write enable stays high for the whole cycle, because a CAS-before-RAS cycle with write enable low would put the device into its test mode. The refresh period is 16 ms, or 128 ms when `EXTENDED` is set. It is divided evenly over `ROWS` requests. Every strobe phase length is computed from a minimum time in nanoseconds and the clock frequency.

A request that waits longer than a slack window without a grant means the refresh period may already be exceeded. In that case the sequencer withdraws the request, drops ready and runs the eight wake-up cycles again.

Top module: `dramRefreshSeq`

## Requirements
- R1: While reset is asserted, `rasN`, `casN` and `weN` are 1, and `ready` and `refReq` are 0.
- R2: After reset is released, no strobe goes low for at least `PAUSE_US*CLK_MHZ` clock cycles.
- R3: After the pause, exactly eight refresh cycles run with no grant needed. `ready` first rises after the eighth cycle, and no earlier.
- R4: In every refresh cycle, `casN` falls while `rasN` is high. `rasN` falls exactly CSR cycles later, with CSR = ceil(10 ns × CLK_MHZ / 1000). `casN` stays low while `rasN` is low and rises in the same cycle as `rasN`.
- R5: `weN` is 1 at every falling edge of `casN` and of `rasN`.
- R6: `rasN` stays low for exactly ceil(60 ns × CLK_MHZ / 1000) cycles. From a rise of `rasN` to the next fall of `casN`, at least RP+PRE cycles pass, where RP = ceil(40 ns) and PRE = ceil(10 ns) in clock cycles.
- R7: While `ready` is 1 and each request is granted at once, `rasN` falls exactly every `P*CLK_MHZ/ROWS` cycles. P is 16000 when `EXTENDED` is 0 and 128000 when it is 1.
- R8: No refresh cycle starts while `refReq` is waiting for a grant. A grant seen at a clock edge while `refReq` is 1 clears `refReq` by the next cycle and starts a refresh cycle. A grant while `refReq` is 0 has no effect.
- R9: A grant on the `SLACK_CYC`-th clock edge with `refReq` high is still accepted, and `ready` stays 1. If no grant comes on any of those edges, `ready` and `refReq` fall at that edge, and eight new wake-up cycles run before `ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Access controller grants the strobes to refresh |
| refReq | output | 1 | A periodic refresh is due |
| rasN | output | 1 | Row strobe request, active low |
| casN | output | 1 | Column strobe request, active low |
| weN | output | 1 | Write-enable level for refresh, held high |
| ready | output | 1 | Wake-up complete; normal accesses may proceed |

## Verification
The hardest situation to reach is the edge of the slack window. The bench must decide on exactly the last edge on which a late grant still counts, and separately on the first edge on which it no longer does, and then follow the recovery through eight fresh wake-up cycles. The bench waits until it sees `refReq` high at a falling clock edge. It then counts edges with the grant held low and raises the grant either one edge before the window closes or not at all. A second instance with the extended period and a different row count shows that the request interval follows from both parameters.

// File: rtl/dramRefPkg.sv
package dramRefPkg;

  typedef enum logic [2:0] {
    PH_PAUSE,
    PH_IDLE,
    PH_PRE,
    PH_CSR,
    PH_RAS,
    PH_RP
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic wakeClr;
    logic wakeInc;
    logic reqTake;
    logic reqDrop;
    logic ivRun;
    logic ivClr;
    logic rasLow;
    logic casLow;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic tmrDone;
    logic lastWake;
    logic reqPend;
    logic overdue;
  } seqStatus_t;

  function automatic int nsToCyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dramRefCtrl.sv
module dramRefCtrl
  import dramRefPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  input  seqStatus_t sts,
  output seqStrobe_t stb,
  output phase_t     phase,
  output logic       ready
);

  phase_t st, stNext;
  logic   readyQ, readyNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= PH_PAUSE;
      readyQ <= 1'b0;
    end else begin
      st     <= stNext;
      readyQ <= readyNext;
    end
  end

  always_comb begin
    stb        = '0;
    stNext     = st;
    readyNext  = readyQ;
    stb.ivRun  = readyQ;
    stb.rasLow = (st == PH_RAS);
    stb.casLow = (st == PH_CSR) || (st == PH_RAS);
    case (st)
      PH_PAUSE: begin
        if (sts.tmrDone) begin
          stb.tmrClr = 1'b1;
          stNext     = PH_PRE;
        end
      end
      PH_IDLE: begin
        stb.tmrClr = 1'b1;
        if (sts.overdue) begin
          readyNext   = 1'b0;
          stb.wakeClr = 1'b1;
          stb.reqDrop = 1'b1;
          stNext      = PH_PRE;
        end else if (sts.reqPend && refGrant) begin
          stb.reqTake = 1'b1;
          stNext      = PH_PRE;
        end
      end
      PH_PRE: begin
        if (sts.tmrDone) begin
          stb.tmrClr = 1'b1;
          stNext     = PH_CSR;
        end
      end
      PH_CSR: begin
        if (sts.tmrDone) begin
          stb.tmrClr = 1'b1;
          stNext     = PH_RAS;
        end
      end
      PH_RAS: begin
        if (sts.tmrDone) begin
          stb.tmrClr = 1'b1;
          stNext     = PH_RP;
        end
      end
      PH_RP: begin
        if (sts.tmrDone) begin
          stb.tmrClr = 1'b1;
          if (!readyQ) begin
            stb.wakeInc = 1'b1;
            if (sts.lastWake) begin
              readyNext = 1'b1;
              stb.ivClr = 1'b1;
              stNext    = PH_IDLE;
            end else begin
              stNext = PH_PRE;
            end
          end else begin
            stNext = PH_IDLE;
          end
        end
      end
      default: stNext = PH_PAUSE;
    endcase
  end

  assign phase = st;
  assign ready = readyQ;

  // R3
  ready_after_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyQ) |-> ($past(st) == PH_RP && $past(sts.lastWake)));

endmodule

// File: rtl/dramRefPath.sv
module dramRefPath
  import dramRefPkg::*;
#(
  parameter int PAUSE_CYC   = 20000,
  parameter int PRE_CYC     = 2,
  parameter int CSR_CYC     = 2,
  parameter int RAS_CYC     = 12,
  parameter int RP_CYC      = 8,
  parameter int IV_CYC      = 3125,
  parameter int SLACK_CYC   = 64,
  parameter int WAKE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  input  seqStrobe_t stb,
  input  phase_t     phSel,
  output seqStatus_t sts,
  output logic       refReq,
  output logic       rasN,
  output logic       casN,
  output logic       weN
);

  localparam int MAXLEN = maxOf(maxOf(maxOf(PAUSE_CYC, PRE_CYC), maxOf(CSR_CYC, RAS_CYC)), RP_CYC);
  localparam int TMR_W  = $clog2(MAXLEN + 1);
  localparam int IV_W   = $clog2(IV_CYC);
  localparam int SL_W   = $clog2(SLACK_CYC);
  localparam int WK_W   = $clog2(WAKE_CYCLES + 1);

  logic [TMR_W-1:0] tmr, phaseLen;
  logic [IV_W-1:0]  ivCnt;
  logic [SL_W-1:0]  waitCnt;
  logic [WK_W-1:0]  wakeCnt;
  logic             pend, ivTick, waitFull;

  // phase timer shared by pause and strobe phases
  always_comb begin
    case (phSel)
      PH_PAUSE: phaseLen = TMR_W'(PAUSE_CYC);
      PH_PRE:   phaseLen = TMR_W'(PRE_CYC);
      PH_CSR:   phaseLen = TMR_W'(CSR_CYC);
      PH_RAS:   phaseLen = TMR_W'(RAS_CYC);
      PH_RP:    phaseLen = TMR_W'(RP_CYC);
      default:  phaseLen = TMR_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tmr <= '0;
    else if (stb.tmrClr) tmr <= '0;
    else                 tmr <= tmr + 1'b1;
  end

  // wake-up cycle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wakeCnt <= '0;
    else if (stb.wakeClr) wakeCnt <= '0;
    else if (stb.wakeInc) wakeCnt <= wakeCnt + 1'b1;
  end

  // distributed refresh interval
  assign ivTick = stb.ivRun && (ivCnt == IV_W'(IV_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ivCnt <= '0;
    else if (stb.ivClr) ivCnt <= '0;
    else if (ivTick)    ivCnt <= '0;
    else if (stb.ivRun) ivCnt <= ivCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          pend <= 1'b0;
    else if (stb.reqDrop || stb.reqTake) pend <= 1'b0;
    else if (ivTick)                    pend <= 1'b1;
  end

  assign refReq = pend && stb.ivRun;

  // grant slack window
  assign waitFull = (waitCnt == SL_W'(SLACK_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     waitCnt <= '0;
    else if (!refReq)              waitCnt <= '0;
    else if (!refGrant && !waitFull) waitCnt <= waitCnt + 1'b1;
  end

  // registered strobe outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
    end else begin
      rasN <= !stb.rasLow;
      casN <= !stb.casLow;
      weN  <= 1'b1;
    end
  end

  assign sts.tmrDone  = (tmr == phaseLen - 1'b1);
  assign sts.lastWake = (wakeCnt == WK_W'(WAKE_CYCLES - 1));
  assign sts.reqPend  = pend;
  assign sts.overdue  = refReq && !refGrant && waitFull;

  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phSel == PH_PAUSE) |-> (rasN && casN));

  // R4
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && !$past(casN)));

  // R4
  cas_rises_with_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casN) |-> $rose(rasN));

  // R5
  we_high_at_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) || $fell(casN)) |-> weN);

  // R8
  grant_clears_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant && phSel == PH_IDLE) |=> (!refReq && phSel == PH_PRE));

  // R9
  overdue_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sts.overdue && phSel == PH_IDLE) |=> !stb.ivRun);

endmodule

// File: rtl/dramRefreshSeq.sv
module dramRefreshSeq
  import dramRefPkg::*;
#(
  parameter int CLK_MHZ     = 200,
  parameter int EXTENDED    = 0,
  parameter int ROWS        = 1024,
  parameter int PAUSE_US    = 100,
  parameter int WAKE_CYCLES = 8,
  parameter int SLACK_CYC   = 64,
  parameter int T_PRE_NS    = 10,
  parameter int T_CSR_NS    = 10,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic ready
);

  localparam int PERIOD_US = (EXTENDED != 0) ? 128000 : 16000;
  localparam int IV_CYC    = PERIOD_US * CLK_MHZ / ROWS;
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int PRE_CYC   = nsToCyc(T_PRE_NS, CLK_MHZ);
  localparam int CSR_CYC   = nsToCyc(T_CSR_NS, CLK_MHZ);
  localparam int RAS_CYC   = nsToCyc(T_RAS_NS, CLK_MHZ);
  localparam int RP_CYC    = nsToCyc(T_RP_NS, CLK_MHZ);

  seqStrobe_t stb;
  seqStatus_t sts;
  phase_t     phase;

  dramRefCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .sts      (sts),
    .stb      (stb),
    .phase    (phase),
    .ready    (ready)
  );

  dramRefPath #(
    .PAUSE_CYC   (PAUSE_CYC),
    .PRE_CYC     (PRE_CYC),
    .CSR_CYC     (CSR_CYC),
    .RAS_CYC     (RAS_CYC),
    .RP_CYC      (RP_CYC),
    .IV_CYC      (IV_CYC),
    .SLACK_CYC   (SLACK_CYC),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .stb      (stb),
    .phSel    (phase),
    .sts      (sts),
    .refReq   (refReq),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN)
  );

endmodule

// File: tb/test_dramRefreshSeq.sv
`timescale 1ns/1ps

module strobeMon #(
  parameter int PRE = 2,
  parameter int CSR = 2,
  parameter int RAS = 12,
  parameter int RP  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  output int   passN,
  output int   failN,
  output int   falls,
  output int   lastFall,
  output int   prevFall,
  output int   firstCas
);
  int  cyc = 0;
  int  casFallAt = 0;
  int  rasFallAt = 0;
  int  lastRasRise = -1;
  logic pr = 1'b1;
  logic pc = 1'b1;

  initial begin
    passN = 0; failN = 0; falls = 0; lastFall = 0; prevFall = 0; firstCas = -1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (ok) passN++;
    else begin
      failN++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (pc && !casN) begin
        if (firstCas < 0) firstCas = cyc;
        casFallAt = cyc;
        chk(rasN == 1'b1, "R4 ras high at cas fall", int'(rasN), 1);
        chk(weN == 1'b1, "R5 we high at cas fall", int'(weN), 1);
        if (lastRasRise >= 0)
          chk(cyc - lastRasRise >= RP + PRE, "R6 precharge gap", cyc - lastRasRise, RP + PRE);
      end
      if (pr && !rasN) begin
        falls++;
        prevFall = lastFall;
        lastFall = cyc;
        rasFallAt = cyc;
        chk(!casN && (cyc - casFallAt == CSR), "R4 cas lead", cyc - casFallAt, CSR);
        chk(weN == 1'b1, "R5 we high at ras fall", int'(weN), 1);
      end
      if (!pr && rasN) begin
        chk(cyc - rasFallAt == RAS, "R6 ras width", cyc - rasFallAt, RAS);
        chk(casN == 1'b1, "R4 cas rises with ras", int'(casN), 1);
        lastRasRise = cyc;
      end
      if (!pc && casN && !(!pr && rasN))
        chk(1'b0, "R4 cas rose alone", int'(rasN), 0);
      pr = rasN;
      pc = casN;
    end
  end
endmodule

module test_dramRefreshSeq;
  localparam int MHZ    = 200;
  localparam int SLACK  = 16;
  localparam int PRE    = (10 * MHZ + 999) / 1000;
  localparam int CSR    = (10 * MHZ + 999) / 1000;
  localparam int RASW   = (60 * MHZ + 999) / 1000;
  localparam int RP     = (40 * MHZ + 999) / 1000;
  localparam int ROWS_A = 1024;
  localparam int ROWS_B = 4096;
  localparam int PAU_A  = 100;
  localparam int PAU_B  = 10;
  localparam int IV_A   = 16000 * MHZ / ROWS_A;
  localparam int IV_B   = 128000 * MHZ / ROWS_B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grantA = 1'b1;
  logic grantB = 1'b1;
  logic reqA, rasA, casA, weA, readyA;
  logic reqB, rasB, casB, weB, readyB;
  int   nPass = 0;
  int   nFail = 0;
  int   pA, fA, fallsA, lastA, prevA, firstA;
  int   pB, fB, fallsB, lastB, prevB, firstB;

  always #2.5 clk = ~clk;

  dramRefreshSeq #(.CLK_MHZ(MHZ), .EXTENDED(0), .ROWS(ROWS_A), .PAUSE_US(PAU_A), .SLACK_CYC(SLACK))
  i_dramRefreshSeq (.clk(clk), .rstN(rstN), .refGrant(grantA), .refReq(reqA),
                    .rasN(rasA), .casN(casA), .weN(weA), .ready(readyA));

  dramRefreshSeq #(.CLK_MHZ(MHZ), .EXTENDED(1), .ROWS(ROWS_B), .PAUSE_US(PAU_B), .SLACK_CYC(SLACK))
  i_dramRefreshSeqExt (.clk(clk), .rstN(rstN), .refGrant(grantB), .refReq(reqB),
                       .rasN(rasB), .casN(casB), .weN(weB), .ready(readyB));

  strobeMon #(.PRE(PRE), .CSR(CSR), .RAS(RASW), .RP(RP)) i_monA (
    .clk(clk), .rstN(rstN), .rasN(rasA), .casN(casA), .weN(weA),
    .passN(pA), .failN(fA), .falls(fallsA), .lastFall(lastA), .prevFall(prevA), .firstCas(firstA));

  strobeMon #(.PRE(PRE), .CSR(CSR), .RAS(RASW), .RP(RP)) i_monB (
    .clk(clk), .rstN(rstN), .rasN(rasB), .casN(casB), .weN(weB),
    .passN(pB), .failN(fB), .falls(fallsB), .lastFall(lastB), .prevFall(prevB), .firstCas(firstB));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (ok) nPass++;
    else begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    int tp, tf;
    tp = nPass + pA + pB;
    tf = nFail + fA + fB;
    $display("%0d/%0d checks passed", tp, tp + tf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    report();
    $finish;
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({rasA, casA, weA, readyA, reqA} == 5'b11100, "R1 reset state A", int'({rasA, casA, weA, readyA, reqA}), 28);
    chk({rasB, casB, weB, readyB, reqB} == 5'b11100, "R1 reset state B", int'({rasB, casB, weB, readyB, reqB}), 28);
    rstN = 1'b1;

    for (int i = 0; i < 30000 && !readyA; i++) @(negedge clk);
    chk(readyA == 1'b1, "R3 ready reached", int'(readyA), 1);
    chk(fallsA == 8, "R3 wake cycles before ready", fallsA, 8);
    chk(firstA >= PAU_A * MHZ, "R2 pause length", firstA, PAU_A * MHZ);

    // R7 and R8: grant held high, idle grant ignored between requests
    for (int i = 0; i < 4 * IV_A && fallsA < 11; i++) @(negedge clk);
    chk(lastA - prevA == IV_A, "R7 standard interval", lastA - prevA, IV_A);

    // R8 withheld grant, then R9 last allowed edge
    grantA = 1'b0;
    for (int i = 0; i < IV_A + 10 && !reqA; i++) @(negedge clk);
    chk(reqA == 1'b1, "R7 request raised", int'(reqA), 1);
    f0 = fallsA;
    repeat (SLACK - 1) @(negedge clk);
    chk(reqA == 1'b1, "R8 request held while ungranted", int'(reqA), 1);
    chk(fallsA == f0, "R8 no cycle without grant", fallsA, f0);
    grantA = 1'b1;
    @(negedge clk);
    grantA = 1'b0;
    chk(reqA == 1'b0, "R8 request cleared by grant", int'(reqA), 0);
    chk(readyA == 1'b1, "R9 late grant accepted", int'(readyA), 1);
    repeat (PRE + CSR + 3) @(negedge clk);
    chk(fallsA == f0 + 1, "R8 cycle started after grant", fallsA, f0 + 1);

    // R9 overdue recovery
    for (int i = 0; i < IV_A + 10 && !reqA; i++) @(negedge clk);
    repeat (SLACK) @(negedge clk);
    chk(readyA == 1'b0, "R9 ready dropped on overdue", int'(readyA), 0);
    chk(reqA == 1'b0, "R9 request withdrawn", int'(reqA), 0);
    f0 = fallsA;
    for (int i = 0; i < 1000 && !readyA; i++) @(negedge clk);
    chk(readyA == 1'b1, "R9 ready restored", int'(readyA), 1);
    chk(fallsA - f0 == 8, "R9 R3 wake cycles repeated without grant", fallsA - f0, 8);

    // extended instance
    chk(readyB == 1'b1, "R3 extended ready", int'(readyB), 1);
    chk(firstB >= PAU_B * MHZ, "R2 extended pause", firstB, PAU_B * MHZ);
    chk(fallsB >= 10, "R7 extended refreshes seen", fallsB, 10);
    chk(lastB - prevB == IV_B, "R7 extended interval", lastB - prevB, IV_B);

    report();
    $finish;
  end
endmodule